// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches recently used virtual-to-physical page translations and resolves a lookup against all of its slots in parallel. A requester presents a 32-bit virtual address with a load or store qualifier. On the next clock edge the block returns the physical address, built from the stored frame number and the untranslated 13-bit page offset (8 KB pages), or it raises a miss or a protection fault. Every slot holds a page number, a frame number, a valid flag, a write permission flag, a referenced flag and a modified flag. A hit sets the referenced flag. A store that is allowed to complete sets the modified flag.

A privileged fill port installs one translation per cycle. If the page is already resident, the fill overwrites that slot. Otherwise it takes a free slot, or, when every slot is occupied, a slot chosen by hardware that is never the one hit most recently. A flush input invalidates every slot in one cycle. The miss output is the hook for an external handler or table walker, which then uses the fill port.

Top module: `xlat_buffer`

## Requirements
- R1: While and after reset, every slot is invalid and rsp_valid, rsp_miss, rsp_prot, rsp_ref, rsp_dirty, multi_hit and rsp_paddr are all zero. The first lookup after reset misses.
- R2: A lookup whose page number (bits 31:13) matches a valid slot gives rsp_valid=1 and rsp_miss=0 one cycle later, with rsp_paddr = {frame number, vaddr[12:0]}.
- R3: A lookup that matches no valid slot gives rsp_valid=1, rsp_miss=1, rsp_prot=0 and rsp_paddr=0 one cycle later.
- R4: A store that hits a slot whose write permission is clear gives rsp_prot=1, rsp_miss=0 and rsp_paddr=0, and it leaves that slot's modified flag clear.
- R5: On any hit, rsp_ref reports the slot's referenced flag as it was before that access, and the access then sets the flag. The first hit after a fill therefore reports 0, and later hits report 1.
- R6: On any hit, rsp_dirty reports the slot's modified flag before that access. A permitted store sets the flag. Loads never set it.
- R7: Fills of distinct pages into a buffer that is not full occupy distinct slots, so all 48 can be resident at once and each of them translates.
- R8: A fill whose page number is already resident rewrites that slot with the new frame and permission and clears its referenced and modified flags.
- R9: When every slot is valid, a fill of a new page never evicts the slot hit most recently.
- R10: A flush invalidates every slot, so any lookup presented in the cycle after the flush misses.
- R11: Because fills never duplicate a resident page, multi_hit (raised when two valid slots match one lookup; the lowest index is then used) stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | 19 | Page number being installed |
| fill_pfn | input | 19 | Frame number being installed |
| fill_wr_en | input | 1 | Write permission of the new slot |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_paddr | output | 32 | Translated address (0 on miss or fault) |
| rsp_miss | output | 1 | No valid slot matched |
| rsp_prot | output | 1 | Store to a write-protected page |
| rsp_ref | output | 1 | Referenced flag of the hit slot before the access |
| rsp_dirty | output | 1 | Modified flag of the hit slot before the access |
| multi_hit | output | 1 | Duplicate match seen on the last lookup |

## Verification
Each lookup's response is registered and appears after the first rising edge that follows the request. Fills, flushes and flag updates take effect at that same edge, so a lookup presented in the next cycle already sees them. The driver applies each operation in the low phase of the clock and queues the expected response. The monitor samples at the following falling edge, exactly one edge later, and pops the queue there. The effect of a flag update is checked through rsp_ref and rsp_dirty on a later lookup of the same page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFS_W = 13;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = 19;
    localparam int PA_W  = PFN_W + OFS_W;

    typedef struct packed {
        logic             valid;
        logic             wr_ok;
        logic             refd;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } xlat_entry_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            miss;
        logic            prot;
        logic            refd;
        logic            dirty;
        logic            multi;
    } xlat_rsp_t;

    function automatic logic [PA_W-1:0] make_paddr(logic [PFN_W-1:0] pfn,
                                                   logic [VA_W-1:0]  va);
        return {pfn, va[OFS_W-1:0]};
    endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N_ENT = 48,
    parameter int IW    = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [VPN_W-1:0]            key,
    input  logic [N_ENT-1:0][VPN_W-1:0] vpns,
    input  logic [N_ENT-1:0]            valid_vec,
    output logic                        hit,
    output logic [IW-1:0]               idx,
    output logic                        multi
);
    logic [N_ENT-1:0] eq;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
        assign eq[gi] = valid_vec[gi] && (vpns[gi] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (eq[i]) idx = IW'(i);
        end
    end

    assign hit   = |eq;
    assign multi = |(eq & (eq - 1'b1));

    AST_MATCH_KEY: assert property (@(posedge clk) disable iff (rst)
        hit |-> (valid_vec[idx] && vpns[idx] == key)); // R2
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N_ENT = 48,
    parameter int IW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] valid_vec,
    input  logic [IW-1:0]    last_hit,
    input  logic             advance,
    output logic [IW-1:0]    victim
);
    logic [IW-1:0] ptr, rr_pick, free_idx;
    logic          free_found;

    function automatic logic [IW-1:0] step(logic [IW-1:0] x);
        return (x == IW'(N_ENT - 1)) ? '0 : x + 1'b1;
    endfunction

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    assign rr_pick = (ptr == last_hit) ? step(ptr) : ptr;
    assign victim  = free_found ? free_idx : rr_pick;

    always_ff @(posedge clk) begin
        if (rst)                         ptr <= '0;
        else if (advance && !free_found) ptr <= step(rr_pick);
    end

    if (N_ENT > 1) begin : g_chk
        AST_VICTIM_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
            (&valid_vec) |-> (victim != last_hit)); // R9
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int N_ENT = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_store,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wr_en,
    input  logic             flush,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_miss,
    output logic             rsp_prot,
    output logic             rsp_ref,
    output logic             rsp_dirty,
    output logic             multi_hit
);
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    xlat_entry_t                 tbl [N_ENT];
    logic [N_ENT-1:0]            valid_vec;
    logic [N_ENT-1:0][VPN_W-1:0] vpn_arr;
    xlat_rsp_t                   rsp_q;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_flat
        assign valid_vec[gi] = tbl[gi].valid;
        assign vpn_arr[gi]   = tbl[gi].vpn;
    end

    logic [VPN_W-1:0] req_vpn;
    logic             lk_hit, lk_multi, fm_hit, fm_multi;
    logic [IW-1:0]    lk_idx, fm_idx, vic_idx, fill_idx, last_hit;
    xlat_entry_t      hit_ent;
    logic             store_blocked;

    assign req_vpn = req_vaddr[VA_W-1:OFS_W];

    xlat_match #(.N_ENT(N_ENT), .IW(IW)) u_lookup (
        .clk(clk), .rst(rst), .key(req_vpn), .vpns(vpn_arr),
        .valid_vec(valid_vec), .hit(lk_hit), .idx(lk_idx), .multi(lk_multi));

    xlat_match #(.N_ENT(N_ENT), .IW(IW)) u_fillmatch (
        .clk(clk), .rst(rst), .key(fill_vpn), .vpns(vpn_arr),
        .valid_vec(valid_vec), .hit(fm_hit), .idx(fm_idx), .multi(fm_multi));

    xlat_victim #(.N_ENT(N_ENT), .IW(IW)) u_victim (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .last_hit(last_hit),
        .advance(fill_valid && !flush && !fm_hit), .victim(vic_idx));

    assign fill_idx      = fm_hit ? fm_idx : vic_idx;
    assign hit_ent       = tbl[lk_idx];
    assign store_blocked = req_store && !hit_ent.wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
            rsp_q    <= '0;
            last_hit <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.miss  <= req_valid && !lk_hit;
            rsp_q.prot  <= req_valid && lk_hit && store_blocked;
            rsp_q.paddr <= (req_valid && lk_hit && !store_blocked)
                           ? make_paddr(hit_ent.pfn, req_vaddr) : '0;
            rsp_q.refd  <= req_valid && lk_hit && hit_ent.refd;
            rsp_q.dirty <= req_valid && lk_hit && hit_ent.dirty;
            rsp_q.multi <= (req_valid && lk_multi) || (fill_valid && fm_multi);
            if (req_valid && lk_hit) begin
                tbl[lk_idx].refd <= 1'b1;
                if (req_store && hit_ent.wr_ok) tbl[lk_idx].dirty <= 1'b1;
                last_hit <= lk_idx;
            end
            if (fill_valid) begin
                tbl[fill_idx] <= '{valid: 1'b1, wr_ok: fill_wr_en, refd: 1'b0,
                                   dirty: 1'b0, vpn: fill_vpn, pfn: fill_pfn};
            end
            if (flush) begin
                for (int i = 0; i < N_ENT; i++) tbl[i].valid <= 1'b0;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_prot  = rsp_q.prot;
    assign rsp_ref   = rsp_q.refd;
    assign rsp_dirty = rsp_q.dirty;
    assign multi_hit = rsp_q.multi;

    AST_MISS_NOT_PROT: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> !rsp_prot); // R4
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_miss && !rsp_prot)
        |-> (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))); // R2
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss || rsp_prot) |-> (rsp_paddr == '0)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)); // R10
    AST_NO_DUP: assert property (@(posedge clk) disable iff (rst)
        !multi_hit); // R11
    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
endmodule

// File: tb/tb_xlat_buffer.sv
module tb_xlat_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        fill_valid = 1'b0;
    logic [18:0] fill_vpn = '0;
    logic [18:0] fill_pfn = '0;
    logic        fill_wr_en = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_miss, rsp_prot, rsp_ref, rsp_dirty, multi_hit;
    logic [31:0] rsp_paddr;

    xlat_buffer dut (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] paddr;
        logic        miss;
        logic        prot;
        logic        refd;
        logic        dirty;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    task automatic lookup(input logic [18:0] vpn, input logic [12:0] ofs,
                          input logic st, input logic hit, input logic [18:0] pfn,
                          input logic prot, input logic rf, input logic dt,
                          input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, ofs};
        req_store = st;
        e.paddr = (hit && !prot) ? {pfn, ofs} : 32'h0;
        e.miss  = !hit;
        e.prot  = prot;
        e.refd  = hit ? rf : 1'b0;
        e.dirty = hit ? dt : 1'b0;
        e.tag   = tag;
        exp_q.push_back(e);
        @(posedge clk);
        #1 req_valid = 1'b0;
        req_store = 1'b0;
    endtask

    task automatic fill(input logic [18:0] vpn, input logic [18:0] pfn,
                        input logic we);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_pfn   = pfn;
        fill_wr_en = we;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: response is due at the falling edge after the request's rising edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(multi_hit == 1'b0, "R11 multi_hit", {31'b0, multi_hit}, 32'h0);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected response", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
                    chk(rsp_miss == e.miss, {e.tag, " miss"}, {31'b0, rsp_miss}, {31'b0, e.miss});
                    chk(rsp_prot == e.prot, {e.tag, " prot"}, {31'b0, rsp_prot}, {31'b0, e.prot});
                    chk(rsp_ref == e.refd, {e.tag, " ref"}, {31'b0, rsp_ref}, {31'b0, e.refd});
                    chk(rsp_dirty == e.dirty, {e.tag, " dirty"}, {31'b0, rsp_dirty}, {31'b0, e.dirty});
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(rsp_valid == 0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk(rsp_miss == 0 && rsp_prot == 0, "R1 flags", {30'b0, rsp_miss, rsp_prot}, 32'h0);
        chk(rsp_paddr == 0, "R1 paddr", rsp_paddr, 32'h0);
        lookup(19'h091A2, 13'h1678, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1 first lookup misses");

        // R2 R5 R6 basic hit, referenced and modified flags
        fill(19'h00010, 19'h00ABC, 1'b1);
        lookup(19'h00010, 13'h0123, 1'b0, 1'b1, 19'h00ABC, 1'b0, 1'b0, 1'b0, "R2 R5 first hit");
        lookup(19'h00010, 13'h1FFF, 1'b0, 1'b1, 19'h00ABC, 1'b0, 1'b1, 1'b0, "R5 ref set");
        lookup(19'h00010, 13'h0000, 1'b1, 1'b1, 19'h00ABC, 1'b0, 1'b1, 1'b0, "R6 store ok");
        lookup(19'h00010, 13'h0040, 1'b0, 1'b1, 19'h00ABC, 1'b0, 1'b1, 1'b1, "R6 dirty seen");

        // R4 protected store
        fill(19'h00020, 19'h00077, 1'b0);
        lookup(19'h00020, 13'h0008, 1'b1, 1'b1, 19'h00077, 1'b1, 1'b0, 1'b0, "R4 prot fault");
        lookup(19'h00020, 13'h0010, 1'b0, 1'b1, 19'h00077, 1'b0, 1'b1, 1'b0, "R4 dirty stays clear");
        lookup(19'h7FFFF, 13'h0010, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R3 miss");

        // R8 overwrite of resident page
        fill(19'h00010, 19'h00DEF, 1'b1);
        lookup(19'h00010, 13'h0ABC, 1'b0, 1'b1, 19'h00DEF, 1'b0, 1'b0, 1'b0, "R8 rewrite");

        // R10 flush
        do_flush();
        lookup(19'h00010, 13'h0ABC, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 flushed a");
        lookup(19'h00020, 13'h0001, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 flushed b");

        // R7 fill all slots
        for (int i = 0; i < 48; i++) fill(19'h00100 + 19'(i), 19'h00200 + 19'(i), 1'b1);
        for (int i = 0; i < 48; i++)
            lookup(19'h00100 + 19'(i), 13'(i * 7), 1'b0, 1'b1, 19'h00200 + 19'(i),
                   1'b0, 1'b0, 1'b0, "R7 all resident");

        // R9 most recently hit slot survives overflow fills
        lookup(19'h00105, 13'h0005, 1'b0, 1'b1, 19'h00205, 1'b0, 1'b1, 1'b0, "R9 mark last");
        for (int k = 0; k < 60; k++) fill(19'h00300 + 19'(k), 19'h00400 + 19'(k), 1'b1);
        lookup(19'h0033B, 13'h0002, 1'b0, 1'b1, 19'h0043B, 1'b0, 1'b0, 1'b0, "R9 newest fill");
        lookup(19'h00105, 13'h0006, 1'b0, 1'b1, 19'h00205, 1'b0, 1'b1, 1'b0, "R9 survivor");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 responses outstanding", exp_q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule